// File: doc/BRIEF.md
# Prioritized Three-Slot Transmit Scheduler

This block holds three outgoing message slots for a CAN-style controller and decides which of them is offered to the bus each time the controller is allowed to arbitrate. The host fills a slot's 13-byte message store, gives the slot an 8-bit rank, and then clears the slot's free flag to mark it pending. When the bit engine signals that arbitration may begin, the scheduler compares the ranks of all pending slots and passes the winner's index and rank to the engine. The engine reads the message bytes of that slot through a registered read port.

The engine reports how each attempt ends. After a success, the slot's free flag is set and the slot's interrupt line rises unless that line is masked. After an error or a lost arbitration, the slot stays pending and competes again at the next arbitration window. Ranks are compared afresh at every window, so a host that changes ranks between attempts changes the outcome. While a slot is being sent, its rank and its bytes are frozen.

Top module: `tx_slot_sched`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `free_flags` reads 3'b111, `tx_req` reads 0 and `irq` reads 0.
- R2: A `mark_rdy` pulse naming slot s (0..2) clears bit s of `free_flags` on the next cycle. Bit i of every 3-bit vector refers to slot i.
- R3: When `arb_start` is seen with no attempt in progress and at least one slot pending, `tx_req` goes to 1 on the next cycle, and `tx_slot` gives the pending slot with the numerically smallest rank.
- R4: When several pending slots hold the same smallest rank, the one with the lowest index is chosen.
- R5: When `arb_start` is seen with no slot pending, `tx_req` stays 0.
- R6: `tx_ok` during an attempt drops `tx_req` and sets the free flag of `tx_slot` on the next cycle.
- R7: `tx_err` or `arb_lost` during an attempt drops `tx_req` and leaves the slot pending. The next `arb_start` ranks all pending slots again using their current ranks.
- R8: `irq` is registered and follows `free_flags & ~irq_mask`, changing on the same edge as the free flags.
- R9: `tx_prio` shows the winner's rank as sampled at the start of the attempt. Rank writes and byte writes aimed at the slot in flight are dropped, not deferred.
- R10: `rd_data` returns byte `rd_addr` (0..12) of slot `tx_slot` one cycle after `rd_addr` is presented.
- R11: `arb_start` during an attempt changes neither `tx_slot` nor `tx_prio`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_we | input | 1 | Write one message byte |
| byte_slot | input | 2 | Slot of the byte write |
| byte_addr | input | 4 | Byte index 0..12 |
| byte_wdata | input | 8 | Byte value |
| prio_we | input | 1 | Write a slot rank |
| prio_slot | input | 2 | Slot of the rank write |
| prio_wdata | input | 8 | Rank; lower value wins |
| mark_rdy | input | 1 | Mark a slot pending (clears its free flag) |
| rdy_slot | input | 2 | Slot to mark pending |
| irq_mask | input | 3 | Per-slot interrupt mask, 1 = masked |
| arb_start | input | 1 | Engine may arbitrate now |
| tx_ok | input | 1 | Attempt finished successfully |
| tx_err | input | 1 | Attempt ended in a bus error |
| arb_lost | input | 1 | Attempt lost arbitration |
| rd_addr | input | 4 | Engine byte read index |
| free_flags | output | 3 | Per-slot free flag, 1 = free |
| irq | output | 3 | Per-slot transmit interrupt |
| tx_req | output | 1 | An attempt is in progress |
| tx_slot | output | 2 | Slot in flight |
| tx_prio | output | 8 | Rank of slot in flight |
| rd_data | output | 8 | Byte read for the engine |

## Verification
The selection is driven with rank sets where the winner sits at each of the three indices, where every slot shares one rank, where two slots tie below a third, and where only a subset is pending, so a reversed comparison, a highest-index tie rule or a picker that ignores the pending mask each produce a different slot. A window with nothing pending separates a request raised by default from one raised by a real winner. Retry sequences change ranks between attempts to show that the choice is made again each window, and writes during an attempt are followed by a retry and by byte reads, so a write that slipped through would show up as a different winner or a different byte.

// File: rtl/tss_pkg.sv
package tss_pkg;
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_DONE  = 2'd1,
    EV_RETRY = 2'd2
  } tx_evt_e;
endpackage

// File: rtl/tss_prio_pick.sv
module tss_prio_pick #(
  parameter int NSLOT = 3,
  parameter int PW    = 8,
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic [NSLOT-1:0]         pend,
  input  logic [NSLOT-1:0][PW-1:0] rank,
  output logic                     found,
  output logic [SW-1:0]            win
);
  logic [PW-1:0] best;

  always_comb begin
    found = 1'b0;
    win   = '0;
    best  = '1;
    for (int i = 0; i < NSLOT; i++) begin
      // strict compare keeps the lower index on a tie
      if (pend[i] && (!found || rank[i] < best)) begin
        found = 1'b1;
        win   = SW'(i);
        best  = rank[i];
      end
    end
  end

  always_comb begin
    if (found) begin
      for (int i = 0; i < NSLOT; i++) begin
        if (pend[i])
          p_pick_min_r3: assert (rank[win] <= rank[i]);
        if (pend[i] && rank[i] == rank[win])
          p_tie_low_r4: assert (int'(win) <= i);
      end
    end
  end
endmodule

// File: rtl/tss_msg_store.sv
module tss_msg_store #(
  parameter int NSLOT = 3,
  parameter int NBYTE = 13,
  parameter int DW    = 8,
  localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int AW    = $clog2(NBYTE),
  localparam int DEPTH = NSLOT << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [SW-1:0] wslot,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [SW-1:0] rslot,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[{wslot, waddr}] <= wdata;
    rdata <= mem[{rslot, raddr}];
  end
endmodule

// File: rtl/tx_slot_sched.sv
module tx_slot_sched #(
  parameter int NSLOT = 3,
  parameter int PW    = 8,
  parameter int DW    = 8,
  parameter int NBYTE = 13,
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int AW   = $clog2(NBYTE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_we,
  input  logic [SW-1:0]    byte_slot,
  input  logic [AW-1:0]    byte_addr,
  input  logic [DW-1:0]    byte_wdata,
  input  logic             prio_we,
  input  logic [SW-1:0]    prio_slot,
  input  logic [PW-1:0]    prio_wdata,
  input  logic             mark_rdy,
  input  logic [SW-1:0]    rdy_slot,
  input  logic [NSLOT-1:0] irq_mask,
  input  logic             arb_start,
  input  logic             tx_ok,
  input  logic             tx_err,
  input  logic             arb_lost,
  input  logic [AW-1:0]    rd_addr,
  output logic [NSLOT-1:0] free_flags,
  output logic [NSLOT-1:0] irq,
  output logic             tx_req,
  output logic [SW-1:0]    tx_slot,
  output logic [PW-1:0]    tx_prio,
  output logic [DW-1:0]    rd_data
);
  import tss_pkg::*;

  logic [NSLOT-1:0]         free_q, free_d;
  logic [NSLOT-1:0]         irq_q;
  logic [NSLOT-1:0][PW-1:0] rank_q;
  logic                     busy_q;
  logic [SW-1:0]            act_q;
  logic [PW-1:0]            act_rank_q;
  logic                     pick_found;
  logic [SW-1:0]            pick_win;
  tx_evt_e                  evt;
  logic                     byte_ok, prio_ok, rdy_ok;

  tss_prio_pick #(.NSLOT(NSLOT), .PW(PW)) pick_i (
    .pend  (~free_q),
    .rank  (rank_q),
    .found (pick_found),
    .win   (pick_win)
  );

  // writes to the slot in flight are dropped
  assign byte_ok = byte_we && int'(byte_slot) < NSLOT && int'(byte_addr) < NBYTE
                   && !(busy_q && byte_slot == act_q);
  assign prio_ok = prio_we && int'(prio_slot) < NSLOT
                   && !(busy_q && prio_slot == act_q);
  assign rdy_ok  = mark_rdy && int'(rdy_slot) < NSLOT
                   && !(busy_q && rdy_slot == act_q);

  tss_msg_store #(.NSLOT(NSLOT), .NBYTE(NBYTE), .DW(DW)) store_i (
    .clk   (clk),
    .we    (byte_ok),
    .wslot (byte_slot),
    .waddr (byte_addr),
    .wdata (byte_wdata),
    .rslot (act_q),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  always_comb begin
    if (busy_q && tx_ok)                 evt = EV_DONE;
    else if (busy_q && (tx_err || arb_lost)) evt = EV_RETRY;
    else                                 evt = EV_NONE;
  end

  always_comb begin
    free_d = free_q;
    if (rdy_ok)
      free_d[rdy_slot] = 1'b0;
    if (evt == EV_DONE)
      free_d[act_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q     <= '1;
      irq_q      <= '0;
      busy_q     <= 1'b0;
      act_q      <= '0;
      act_rank_q <= '0;
    end else begin
      free_q <= free_d;
      irq_q  <= free_d & ~irq_mask;
      if (evt != EV_NONE) begin
        busy_q <= 1'b0;
      end else if (!busy_q && arb_start && pick_found) begin
        busy_q     <= 1'b1;
        act_q      <= pick_win;
        act_rank_q <= rank_q[pick_win];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rank_q <= '0;
    else if (prio_ok)
      rank_q[prio_slot] <= prio_wdata;
  end

  assign free_flags = free_q;
  assign irq        = irq_q;
  assign tx_req     = busy_q;
  assign tx_slot    = act_q;
  assign tx_prio    = act_rank_q;

  p_req_pending_r3: assert property (@(posedge clk) disable iff (rst)
    tx_req |-> !free_flags[tx_slot]);
  p_none_no_req_r5: assert property (@(posedge clk) disable iff (rst)
    (!tx_req && arb_start && (&free_flags)) |=> !tx_req);
  p_done_frees_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_req && tx_ok) |=> (!tx_req && free_flags[$past(tx_slot)]));
  p_retry_pending_r7: assert property (@(posedge clk) disable iff (rst)
    (tx_req && !tx_ok && (tx_err || arb_lost)) |=> (!tx_req && !free_flags[$past(tx_slot)]));
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (tx_req && !tx_ok && !tx_err && !arb_lost) |=> ($stable(tx_slot) && $stable(tx_prio) && tx_req));
  p_irq_mask_r8: assert property (@(posedge clk) disable iff (rst)
    (irq & irq_mask) == '0 || !$stable(irq_mask));
endmodule

// File: tb/tx_slot_sched_tb_top.sv
module tx_slot_sched_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_we = 0, prio_we = 0, mark_rdy = 0;
  logic [1:0] byte_slot = 0, prio_slot = 0, rdy_slot = 0;
  logic [3:0] byte_addr = 0, rd_addr = 0;
  logic [7:0] byte_wdata = 0, prio_wdata = 0;
  logic [2:0] irq_mask = 0;
  logic       arb_start = 0, tx_ok = 0, tx_err = 0, arb_lost = 0;
  logic [2:0] free_flags, irq;
  logic       tx_req;
  logic [1:0] tx_slot;
  logic [7:0] tx_prio, rd_data;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  tx_slot_sched dut_i (
    .clk(clk), .rst(rst),
    .byte_we(byte_we), .byte_slot(byte_slot), .byte_addr(byte_addr), .byte_wdata(byte_wdata),
    .prio_we(prio_we), .prio_slot(prio_slot), .prio_wdata(prio_wdata),
    .mark_rdy(mark_rdy), .rdy_slot(rdy_slot), .irq_mask(irq_mask),
    .arb_start(arb_start), .tx_ok(tx_ok), .tx_err(tx_err), .arb_lost(arb_lost),
    .rd_addr(rd_addr), .free_flags(free_flags), .irq(irq), .tx_req(tx_req),
    .tx_slot(tx_slot), .tx_prio(tx_prio), .rd_data(rd_data)
  );

  // {rank0, rank1, rank2, pending mask (bit i = slot i), exp_req, exp_slot}
  localparam logic [29:0] VEC [8] = '{
    {8'd10,  8'd20,  8'd30,  3'b111, 1'b1, 2'd0},
    {8'd30,  8'd20,  8'd10,  3'b111, 1'b1, 2'd2},
    {8'd5,   8'd5,   8'd5,   3'b111, 1'b1, 2'd0},
    {8'd9,   8'd3,   8'd3,   3'b111, 1'b1, 2'd1},
    {8'd0,   8'd0,   8'd0,   3'b000, 1'b0, 2'd0},
    {8'd1,   8'd255, 8'd0,   3'b011, 1'b1, 2'd0},
    {8'd200, 8'd100, 8'd50,  3'b100, 1'b1, 2'd2},
    {8'd255, 8'd255, 8'd254, 3'b111, 1'b1, 2'd2}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0; tick();
  endtask

  task automatic set_rank(input int s, input int v);
    prio_we = 1; prio_slot = 2'(s); prio_wdata = 8'(v); tick(); prio_we = 0;
  endtask

  task automatic make_ready(input int s);
    mark_rdy = 1; rdy_slot = 2'(s); tick(); mark_rdy = 0;
  endtask

  task automatic put_byte(input int s, input int a, input int v);
    byte_we = 1; byte_slot = 2'(s); byte_addr = 4'(a); byte_wdata = 8'(v); tick(); byte_we = 0;
  endtask

  task automatic pulse_arb();
    arb_start = 1; tick(); arb_start = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick();
    chk("R1 reset free", int'(free_flags), 7);
    chk("R1 reset req", int'(tx_req), 0);
    chk("R1 reset irq", int'(irq), 0);

    foreach (VEC[k]) begin
      do_reset();
      for (int s = 0; s < 3; s++) set_rank(s, int'(VEC[k][29-8*s -: 8]));
      for (int s = 0; s < 3; s++) if (VEC[k][3+s]) make_ready(s);
      chk("R2 pending mask", int'(free_flags), int'(~VEC[k][5:3] & 3'b111));
      pulse_arb();
      chk("R3/R5 request", int'(tx_req), int'(VEC[k][2]));
      if (VEC[k][2]) begin
        chk("R3/R4 winner", int'(tx_slot), int'(VEC[k][1:0]));
        chk("R9 rank out", int'(tx_prio), int'(VEC[k][29-8*VEC[k][1:0] -: 8]));
      end
    end

    // R1 first cycle after reset, R8 interrupt after reset
    rst = 1; tick(); rst = 0;
    chk("R1 free after reset", int'(free_flags), 7);
    chk("R1 req after reset", int'(tx_req), 0);
    tick();
    chk("R8 irq unmasked", int'(irq), 7);

    // R2 / R8 with mask
    irq_mask = 3'b010;
    set_rank(0, 10); set_rank(1, 20); set_rank(2, 30);
    put_byte(1, 0, 8'hA5); put_byte(1, 12, 8'h3C);
    make_ready(0); make_ready(1);
    chk("R2 flags", int'(free_flags), 4);
    chk("R8 irq follows", int'(irq), 4);

    // R7 retry after error, ranks re-evaluated
    pulse_arb();
    chk("R3 first winner", int'(tx_slot), 0);
    tx_err = 1; tick(); tx_err = 0;
    chk("R7 req drop", int'(tx_req), 0);
    chk("R7 still pending", int'(free_flags), 4);
    set_rank(1, 1);
    pulse_arb();
    chk("R7 re-ranked winner", int'(tx_slot), 1);
    chk("R7 rank", int'(tx_prio), 1);

    // R9 writes to slot in flight dropped; R11 arb during attempt
    set_rank(1, 200);
    put_byte(1, 0, 8'h5A);
    set_rank(0, 0);
    pulse_arb();
    chk("R11 slot held", int'(tx_slot), 1);
    chk("R11 rank held", int'(tx_prio), 1);
    rd_addr = 0; tick();
    chk("R9/R10 byte kept", int'(rd_data), 8'hA5);
    rd_addr = 12; tick();
    chk("R10 last byte", int'(rd_data), 8'h3C);
    arb_lost = 1; tick(); arb_lost = 0;
    chk("R7 lost pending", int'(free_flags), 4);
    set_rank(0, 5);
    pulse_arb();
    chk("R9 dropped rank write", int'(tx_slot), 1);

    // R6 success frees slot; masked irq stays low
    tx_ok = 1; tick(); tx_ok = 0;
    chk("R6 req drop", int'(tx_req), 0);
    chk("R6 freed", int'(free_flags), 6);
    chk("R8 masked irq", int'(irq), 4);
    pulse_arb();
    chk("R6 next winner", int'(tx_slot), 0);
    tx_ok = 1; tick(); tx_ok = 0;
    chk("R6 all free", int'(free_flags), 7);
    chk("R8 irq slot0", int'(irq), 5);
    pulse_arb();
    chk("R5 nothing pending", int'(tx_req), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule